// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block produces the three timing signals that a serial audio port needs when it is the clock master: a root (oversampling) clock, a bit clock and a frame clock whose level marks the left or right channel. One of two source clocks is selected and divided by a programmable prescaler to form the root clock. The bit clock and the frame clock are derived from it through coded ratios, each a multiple of the sample rate. All logic runs on a single system clock. Each source clock arrives as a one-cycle tick that is synchronous to that clock. The root clock leaves the block as a one-cycle enable pulse. The bit clock and the frame clock leave it as registered levels.

Settings come from a mode word and a prescaler word. They are captured into a shadow copy only while `enable` is low, so a configuration stays fixed for the whole of a run. Some settings cannot give whole-number clock ratios, and one sample length cannot be used with some root ratios. For these settings the block raises `cfg_err` and holds its clocks idle. In slave mode the block generates nothing: it routes the external bit clock and frame clock straight to its outputs.

Mode word layout: bit 0 slave, bit 1 source select, bits 3:2 root-ratio code, bits 5:4 bit-ratio code, bits 7:6 sample-length code, bit 8 automatic root ratio, bit 9 automatic bit ratio. Prescaler word layout: bits 8 and up hold the divide value minus one (`PSR_W` bits wide), and bit 15 enables the prescaler.

Top module: `aud_clkgen`

## Requirements
- R1: After reset, `rclk_en`, `bclk`, `fclk` and `cfg_err` are all low.
- R2: While running, `rclk_en` pulses once every N ticks of the selected source, where N is the prescaler field plus one when prescaler bit 15 is set. It pulses on every tick when bit 15 is clear, whatever the field holds.
- R3: Mode bit 1 selects source tick 1 (set) or source tick 0 (clear). When the parameter `HAS_PSR` is 0, source 0 is always used and each tick becomes a root pulse.
- R4: Root-ratio code 0, 1, 2, 3 selects 256, 512, 384, 768 times the sample rate. One frame clock period is that many root periods.
- R5: Bit-ratio code 0, 1, 2, 3 selects 32, 48, 16, 24 times the sample rate. One bit clock period is root ratio / bit ratio root periods.
- R6: The frame clock toggles every bit-ratio/2 bit clock periods, and only in the cycle in which the bit clock falls.
- R7: Sample-length code 2 (24 bits) combined with a root ratio of 256 or 512 raises `cfg_err`, and the clocks stay low while enabled. Code 0 is 16 bits and code 1 is 8 bits.
- R8: A root ratio that is not an integer multiple of the bit ratio raises `cfg_err` and holds the clocks low. So does the reserved sample-length code 3.
- R9: Mode bit 9 sets the bit ratio to twice the sample length. Mode bit 8 sets the root ratio to 256 when the bit ratio is 16 or 32, and to 384 otherwise. Both override the explicit codes.
- R10: With the slave bit set, `bclk` equals `ext_bclk`, `fclk` equals `ext_fclk`, `rclk_en` stays low, and `cfg_err` stays low whatever the ratio settings are.
- R11: While disabled, `bclk` and `fclk` are low. After enable, the first frame clock rise comes root ratio/2 − (root ratio/bit ratio)/2 root periods after the first bit clock rise.
- R12: Changes to the mode or prescaler word while `enable` is high have no effect until the block has been disabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the generator; while low, the settings are captured |
| src_tick | input | 2 | One-cycle ticks of source clocks 0 and 1 |
| mode_word | input | 10 | Mode image (slave, source, ratio codes, sample length, auto bits) |
| psr_word | input | 16 | Prescaler image: divide-minus-one from bit 8, enable at bit 15 |
| ext_bclk | input | 1 | External bit clock, used in slave mode |
| ext_fclk | input | 1 | External frame clock, used in slave mode |
| rclk_en | output | 1 | Root clock enable pulse |
| bclk | output | 1 | Bit clock |
| fclk | output | 1 | Frame clock (low = left channel) |
| cfg_err | output | 1 | Illegal configuration flag |

## Verification
The bench measures the intervals between bit clock and frame clock edges in system cycles. It checks them against periods worked out from the ratio tables, the prescaler and the source tick rate. A swapped code table, or a prescaler that is off by one, shows up as a wrong interval. A source select that is ignored shows up as a halved period. The bench covers several corner cases. Prescaler field zero, and a disabled prescaler with a non-zero field, must both divide by one. Automatic ratios must win over conflicting explicit codes. The 24-bit and fractional-ratio combinations must flag an error and keep the clocks silent; a design that missed one of them would toggle clocks with the wrong period. The bench also rewrites the ratio fields in the middle of a run. A design without the shadow copy would change its period at once, and one that never reloads would keep the old period after re-enable.

// File: rtl/aud_clkgen_pkg.sv
package aud_clkgen_pkg;

   localparam int MODE_W = 10;   // mode word width
   localparam int RW     = 10;   // holds root ratio up to 768
   localparam int BW     = 6;    // holds bit ratio up to 48
   localparam int HW     = 5;    // half-period counters (max 23)

   typedef enum logic [1:0] {
      LEN16  = 2'd0,
      LEN8   = 2'd1,
      LEN24  = 2'd2,
      LENRSV = 2'd3
   } len_e;

   typedef struct packed {
      logic       bfs_auto;   // bit 9
      logic       rfs_auto;   // bit 8
      logic [1:0] len;        // bits 7:6
      logic [1:0] bfs;        // bits 5:4
      logic [1:0] rfs;        // bits 3:2
      logic       src;        // bit 1
      logic       slave;      // bit 0
   } mode_t;

   function automatic logic [RW-1:0] rfs_of(input logic [1:0] code);
      case (code)
         2'd0:    return RW'(256);
         2'd1:    return RW'(512);
         2'd2:    return RW'(384);
         default: return RW'(768);
      endcase
   endfunction

   function automatic logic [BW-1:0] bfs_of(input logic [1:0] code);
      case (code)
         2'd0:    return BW'(32);
         2'd1:    return BW'(48);
         2'd2:    return BW'(16);
         default: return BW'(24);
      endcase
   endfunction

   // Reserved code maps to 16 so the derived ratio never divides by zero.
   function automatic logic [BW-1:0] len_bits_of(input logic [1:0] code);
      case (code)
         LEN8:    return BW'(8);
         LEN24:   return BW'(24);
         default: return BW'(16);
      endcase
   endfunction

endpackage

// File: rtl/aud_clkgen_cfg.sv
module aud_clkgen_cfg
   import aud_clkgen_pkg::*;
#(
   parameter int PSR_W   = 6,
   parameter bit HAS_PSR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [MODE_W-1:0] mode_word,
   input  logic [15:0]       psr_word,
   output logic              slave,
   output logic              src_sel,
   output logic              psr_en,
   output logic [PSR_W-1:0]  div_m1,
   output logic [HW-1:0]     half_m1,
   output logic [HW-1:0]     fhalf_m1,
   output logic              err
);

   mode_t       mode_q;
   logic [15:0] psr_q;

   // Shadow copy follows the inputs only while the block is disabled
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         psr_q  <= '0;
      end else if (!enable) begin
         mode_q <= mode_t'(mode_word);
         psr_q  <= psr_word;
      end
   end

   logic [BW-1:0] len_bits;
   logic [BW-1:0] bfs_e;
   logic [RW-1:0] rfs_e;
   logic [RW-1:0] ratio;
   logic          len_ok;
   logic          bad24;
   logic          frac;

   always_comb begin
      len_bits = len_bits_of(mode_q.len);
      len_ok   = (mode_q.len != LENRSV);
      bfs_e    = mode_q.bfs_auto ? BW'(len_bits << 1) : bfs_of(mode_q.bfs);
      if (mode_q.rfs_auto)
         rfs_e = (bfs_e == BW'(16) || bfs_e == BW'(32)) ? RW'(256) : RW'(384);
      else
         rfs_e = rfs_of(mode_q.rfs);
      bad24    = (mode_q.len == LEN24) && (rfs_e == RW'(256) || rfs_e == RW'(512));
      frac     = (rfs_e % RW'(bfs_e)) != '0;
      ratio    = rfs_e / RW'(bfs_e);
      half_m1  = HW'((ratio >> 1) - RW'(1));
      fhalf_m1 = HW'((bfs_e >> 1) - BW'(1));
      err      = !mode_q.slave && (!len_ok || bad24 || frac);
      slave    = mode_q.slave;
   end

   generate
      if (HAS_PSR) begin : g_psr
         assign src_sel = mode_q.src;
         assign psr_en  = psr_q[15];
         assign div_m1  = psr_q[8 +: PSR_W];
      end else begin : g_nopsr
         assign src_sel = 1'b0;
         assign psr_en  = 1'b0;
         assign div_m1  = '0;
      end
   endgenerate

   logic unused_bits;
   assign unused_bits = ^{psr_q, mode_q};

   // Settings frozen during a run
   p_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && $past(enable)) |-> ($stable(mode_q) && $stable(psr_q)));

endmodule

// File: rtl/aud_clkgen_pre.sv
module aud_clkgen_pre #(
   parameter int PSR_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [1:0]       src_tick,
   input  logic             src_sel,
   input  logic             psr_en,
   input  logic [PSR_W-1:0] div_m1,
   output logic             root_tick
);

   logic             tick;
   logic [PSR_W-1:0] cnt;

   assign tick = src_sel ? src_tick[1] : src_tick[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         root_tick <= 1'b0;
      end else if (!run) begin
         cnt       <= '0;
         root_tick <= 1'b0;
      end else begin
         root_tick <= 1'b0;
         if (tick) begin
            if (!psr_en || cnt == div_m1) begin
               cnt       <= '0;
               root_tick <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   // R2: no root pulse follows a stopped cycle
   p_root_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !root_tick);

   // R2: with a divider above one, root pulses never come back to back
   p_root_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (root_tick && run && psr_en && div_m1 != '0) |=> !root_tick);

endmodule

// File: rtl/aud_clkgen_div.sv
module aud_clkgen_div
   import aud_clkgen_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          root_tick,
   input  logic [HW-1:0] half_m1,
   input  logic [HW-1:0] fhalf_m1,
   output logic          bclk_q,
   output logic          fclk_q
);

   logic [HW-1:0] hcnt;
   logic [HW-1:0] bcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hcnt   <= '0;
         bcnt   <= '0;
         bclk_q <= 1'b0;
         fclk_q <= 1'b0;
      end else if (!run) begin
         hcnt   <= '0;
         bcnt   <= '0;
         bclk_q <= 1'b0;
         fclk_q <= 1'b0;
      end else if (root_tick) begin
         if (hcnt == half_m1) begin
            hcnt   <= '0;
            bclk_q <= ~bclk_q;
            if (bclk_q) begin
               if (bcnt == fhalf_m1) begin
                  bcnt   <= '0;
                  fclk_q <= ~fclk_q;
               end else begin
                  bcnt <= bcnt + 1'b1;
               end
            end
         end else begin
            hcnt <= hcnt + 1'b1;
         end
      end
   end

   // R6: frame clock moves only with a bit clock fall while running
   p_fclk_at_bfall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && !$stable(fclk_q)) |-> $fell(bclk_q));

   // R11: a stopped block starts from the low/left phase
   p_idle_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!bclk_q && !fclk_q));

endmodule

// File: rtl/aud_clkgen.sv
module aud_clkgen
   import aud_clkgen_pkg::*;
#(
   parameter int PSR_W   = 6,
   parameter bit HAS_PSR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [1:0]        src_tick,
   input  logic [MODE_W-1:0] mode_word,
   input  logic [15:0]       psr_word,
   input  logic              ext_bclk,
   input  logic              ext_fclk,
   output logic              rclk_en,
   output logic              bclk,
   output logic              fclk,
   output logic              cfg_err
);

   generate
      if (PSR_W < 1 || PSR_W > 7) begin : g_bad_psr_w
         $error("aud_clkgen: PSR_W must lie in 1..7");
      end
   endgenerate

   logic             slave;
   logic             src_sel;
   logic             psr_en;
   logic [PSR_W-1:0] div_m1;
   logic [HW-1:0]    half_m1;
   logic [HW-1:0]    fhalf_m1;
   logic             err;
   logic             run;
   logic             root_tick;
   logic             gen_bclk;
   logic             gen_fclk;

   aud_clkgen_cfg #(.PSR_W(PSR_W), .HAS_PSR(HAS_PSR)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (enable),
      .mode_word(mode_word),
      .psr_word (psr_word),
      .slave    (slave),
      .src_sel  (src_sel),
      .psr_en   (psr_en),
      .div_m1   (div_m1),
      .half_m1  (half_m1),
      .fhalf_m1 (fhalf_m1),
      .err      (err)
   );

   assign run = enable && !err && !slave;

   aud_clkgen_pre #(.PSR_W(PSR_W)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .src_tick (src_tick),
      .src_sel  (src_sel),
      .psr_en   (psr_en),
      .div_m1   (div_m1),
      .root_tick(root_tick)
   );

   aud_clkgen_div u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .root_tick(root_tick),
      .half_m1  (half_m1),
      .fhalf_m1 (fhalf_m1),
      .bclk_q   (gen_bclk),
      .fclk_q   (gen_fclk)
   );

   assign rclk_en = root_tick;
   assign bclk    = slave ? ext_bclk : gen_bclk;
   assign fclk    = slave ? ext_fclk : gen_fclk;
   assign cfg_err = err;

   // R7 / R8: a flagged configuration keeps every generated clock quiet
   p_err_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> (!bclk && !fclk && !rclk_en));

   // R10: no root pulses once slave mode has settled
   p_slave_noroot_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (slave && $past(slave)) |-> !rclk_en);

endmodule

// File: tb/aud_clkgen_tb.sv
`timescale 1ns/1ps
module aud_clkgen_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic [1:0]  src_tick = 2'b01;
   logic [9:0]  mode_word = '0;
   logic [15:0] psr_word = '0;
   logic        ext_bclk = 1'b0;
   logic        ext_fclk = 1'b0;
   logic        rclk_en, bclk, fclk, cfg_err;
   logic        np_rclk_en, np_bclk, np_fclk, np_err;

   always #2 clk = ~clk;   // 250 MHz

   aud_clkgen u_dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .src_tick(src_tick),
      .mode_word(mode_word), .psr_word(psr_word),
      .ext_bclk(ext_bclk), .ext_fclk(ext_fclk),
      .rclk_en(rclk_en), .bclk(bclk), .fclk(fclk), .cfg_err(cfg_err));

   aud_clkgen #(.HAS_PSR(1'b0)) u_dut_np (
      .clk(clk), .rst_n(rst_n), .enable(enable), .src_tick(src_tick),
      .mode_word(mode_word), .psr_word(psr_word),
      .ext_bclk(ext_bclk), .ext_fclk(ext_fclk),
      .rclk_en(np_rclk_en), .bclk(np_bclk), .fclk(np_fclk), .cfg_err(np_err));

   int    n_chk = 0;
   int    n_fail = 0;
   string cur_req = "R1";
   int    exp_b[$];
   int    exp_f[$];

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // source 1 ticks on every second clock edge, source 0 on every edge
   initial forever begin
      @(negedge clk);
      src_tick[1] = ~src_tick[1];
   end

   // monitor: measures edge intervals and pops expectations
   int cyc = 0;
   int lb = 0, lf = 0, np_lb = 0, np_last = 0, e = 0;
   bit bv = 0, fv = 0, npv = 0, pb = 0, pf = 0, npp = 0;
   always @(negedge clk) begin
      cyc++;
      if (!enable) begin
         bv = 0; fv = 0; npv = 0;
      end else begin
         if (bclk && !pb) begin
            if (bv && exp_b.size() > 0) begin
               e = exp_b.pop_front();
               chk(cyc - lb == e, cur_req, "bclk period", cyc - lb, e);
            end
            lb = cyc; bv = 1;
         end
         if (fclk != pf) begin
            if (fv && exp_f.size() > 0) begin
               e = exp_f.pop_front();
               chk(cyc - lf == e, cur_req, "fclk half period", cyc - lf, e);
            end
            lf = cyc; fv = 1;
         end
         if (np_bclk && !npp) begin
            if (npv) np_last = cyc - np_lb;
            np_lb = cyc; npv = 1;
         end
      end
      pb = bclk; pf = fclk; npp = np_bclk;
   end

   function automatic logic [9:0] mk(input bit sl, input bit src, input logic [1:0] r,
                                     input logic [1:0] b, input logic [1:0] l,
                                     input bit ra, input bit ba);
      return {ba, ra, l, b, r, src, sl};
   endfunction

   function automatic logic [15:0] ps(input bit en, input int m1);
      logic [15:0] p;
      p = '0;
      p[15] = en;
      p[14:8] = 7'(m1);
      return p;
   endfunction

   task automatic setup(input logic [9:0] m, input logic [15:0] p);
      @(negedge clk);
      enable = 1'b0;
      mode_word = m;
      psr_word = p;
      repeat (3) @(negedge clk);
   endtask

   task automatic drain();
      for (int k = 0; k < 20000 && (exp_b.size() > 0 || exp_f.size() > 0); k++)
         @(negedge clk);
      chk(exp_b.size() == 0 && exp_f.size() == 0, cur_req, "edges missing (timeout)",
          exp_b.size() + exp_f.size(), 0);
      exp_b.delete();
      exp_f.delete();
   endtask

   task automatic run_case(input string req, input logic [9:0] m, input logic [15:0] p,
                           input int bper, input int fhalf, input int nb, input int nf);
      cur_req = req;
      setup(m, p);
      chk(cfg_err == 1'b0, req, "cfg_err on legal setting", cfg_err, 0);
      for (int i = 0; i < nb; i++) exp_b.push_back(bper);
      for (int i = 0; i < nf; i++) exp_f.push_back(fhalf);
      enable = 1'b1;
      drain();
      enable = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic err_case(input string req, input logic [9:0] m);
      bit quiet;
      cur_req = req;
      setup(m, ps(0, 0));
      chk(cfg_err == 1'b1, req, "cfg_err on illegal setting", cfg_err, 1);
      enable = 1'b1;
      quiet = 1;
      for (int k = 0; k < 150; k++) begin
         @(negedge clk);
         if (bclk || fclk || rclk_en) quiet = 0;
      end
      chk(quiet, req, "clocks idle under error", quiet, 1);
      enable = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      report();
   end

   initial begin
      int kb, kf;
      repeat (5) @(negedge clk);
      // R1: reset state
      chk({rclk_en, bclk, fclk, cfg_err} == 4'b0, "R1", "outputs in reset",
          {rclk_en, bclk, fclk, cfg_err}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk({rclk_en, bclk, fclk, cfg_err} == 4'b0, "R1", "outputs after reset",
          {rclk_en, bclk, fclk, cfg_err}, 0);

      // R2 R4 R5 R6: 256/32, prescaler divide by 2
      run_case("R2", mk(0,0,2'd0,2'd0,2'd0,0,0), ps(1,1), 16, 256, 3, 2);
      // R2 R4 R5: prescaler off with a non-zero field -> divide by one; 384/48
      run_case("R5", mk(0,0,2'd2,2'd1,2'd2,0,0), ps(0,5), 8, 192, 3, 2);
      // R3 R4: source 1 (tick every 2 cycles), 768/24, divide by 3
      run_case("R3", mk(0,1,2'd3,2'd3,2'd0,0,0), ps(1,2), 192, 2304, 2, 2);
      // R3: the variant without prescaler uses source 0 and divides by one
      chk(np_last == 32, "R3", "no-prescaler bclk period", np_last, 32);
      // R4 R6: 512/16 with prescaler field zero
      run_case("R4", mk(0,0,2'd1,2'd2,2'd0,0,0), ps(1,0), 32, 256, 3, 2);
      // R9: automatic ratios override conflicting codes
      run_case("R9", mk(0,0,2'd3,2'd1,2'd1,1,1), ps(0,0), 16, 128, 3, 2);
      run_case("R9", mk(0,0,2'd0,2'd0,2'd2,1,1), ps(0,0), 8, 192, 3, 2);
      run_case("R9", mk(0,0,2'd3,2'd1,2'd0,0,1), ps(0,0), 24, 384, 3, 2);

      // R7: 24-bit with 512 and with 256
      err_case("R7", mk(0,0,2'd1,2'd0,2'd2,0,0));
      err_case("R7", mk(0,0,2'd0,2'd2,2'd2,0,0));
      // R8: fractional ratio 256/24, reserved length code
      err_case("R8", mk(0,0,2'd0,2'd3,2'd0,0,0));
      err_case("R8", mk(0,0,2'd0,2'd0,2'd3,1,1));

      // R10: slave passthrough with an otherwise illegal ratio
      cur_req = "R10";
      setup(mk(1,0,2'd0,2'd0,2'd2,0,0), ps(1,0));
      chk(cfg_err == 1'b0, "R10", "cfg_err in slave", cfg_err, 0);
      enable = 1'b1;
      for (int v = 0; v < 4; v++) begin
         @(negedge clk);
         ext_bclk = v[0];
         ext_fclk = v[1];
         #1;
         chk(bclk == ext_bclk && fclk == ext_fclk, "R10", "passthrough",
             {bclk, fclk}, {ext_bclk, ext_fclk});
         chk(rclk_en == 1'b0, "R10", "rclk_en in slave", rclk_en, 0);
      end
      enable = 1'b0;
      ext_bclk = 1'b0;
      ext_fclk = 1'b0;
      repeat (4) @(negedge clk);

      // R11: start phase, 512/16 at divide by one
      cur_req = "R11";
      setup(mk(0,0,2'd1,2'd2,2'd0,0,0), ps(0,0));
      chk(bclk == 1'b0 && fclk == 1'b0, "R11", "idle level before enable", {bclk, fclk}, 0);
      enable = 1'b1;
      kb = -1;
      kf = -1;
      for (int k = 0; k < 2000 && kf < 0; k++) begin
         @(negedge clk);
         if (bclk && kb < 0) kb = k;
         if (fclk && kf < 0) kf = k;
      end
      chk(kf - kb == 240, "R11", "first fclk rise after first bclk rise", kf - kb, 240);
      enable = 1'b0;
      repeat (4) @(negedge clk);

      // R12: rewrite fields during a run, old periods must hold
      cur_req = "R12";
      setup(mk(0,0,2'd1,2'd2,2'd0,0,0), ps(0,0));
      for (int i = 0; i < 3; i++) exp_b.push_back(32);
      for (int i = 0; i < 2; i++) exp_f.push_back(256);
      enable = 1'b1;
      repeat (10) @(negedge clk);
      mode_word = mk(0,0,2'd3,2'd2,2'd0,0,0);
      psr_word = ps(1,3);
      drain();
      // after re-enable the new setting (768/16, divide by 4) applies
      enable = 1'b0;
      repeat (4) @(negedge clk);
      for (int i = 0; i < 2; i++) exp_b.push_back(192);
      for (int i = 0; i < 2; i++) exp_f.push_back(1536);
      enable = 1'b1;
      drain();
      enable = 1'b0;
      repeat (4) @(negedge clk);

      report();
   end

endmodule